// File: doc/BRIEF.md
# DMA Channel Register Bank with Start Qualification

This block holds the software-visible configuration of a seven-channel DMA controller and decides, every cycle, which channels may move data. Each channel owns three 32-bit registers: a base address, a block control and a channel control. The channel control word carries an enable/busy flag in bit 24 and a manual start trigger in bit 28. One global control word sits above the channels. For each channel it holds a master enable and a 3-bit priority code.

A 32-bit register bus with separate write and read strobes reaches all of these registers. Read data is registered and returned one cycle after the read strobe. Each channel also has an external request line from its peripheral. A channel is cleared to go only when three things are true: its master enable is set, its busy flag is set and its request is present. The transfer engine sits outside this block. It reports the end of a channel's transfer, or a bus error, with one-cycle pulses, and either pulse drops that channel's busy flag. When several channels qualify together, a one-hot grant names the lowest-numbered one.

Top module: `dma_regbank`

## Requirements
- R1: After synchronous reset, the global control word reads 0x07654321. Every channel register reads 0. `may_xfer` and `grant` are 0.
- R2: A channel's registers sit at byte offset 16·n plus 0x0 (base address), 0x4 (block control) and 0x8 (channel control), for n = 0..6. Each holds all 32 written bits. Read data and `rvalid` appear the cycle after `rd_en`.
- R3: The global control word is at offset 0x70 and holds all 32 written bits. Channel n's priority is in bits [4n+2:4n] and its master enable is in bit 4n+3.
- R4: These offsets are unmapped: offset 0xC inside any channel slot, 0x74 through 0x7F, anything above 0x7F, and any address that is not word aligned. A read of an unmapped offset returns 0xFFFFFFFF. A write to an unmapped offset changes no register.
- R5: `may_xfer[n]` is high exactly when three conditions hold: master enable n is set, channel-control bit 24 of channel n is set, and `req_i[n]` was high at the previous clock edge.
- R6: A `done_i[n]` pulse clears bit 24 of channel n's control word at that edge. The other bits of that word are kept.
- R7: An `err_i[n]` pulse clears bit 24 of channel n's control word in the same way as `done_i[n]`.
- R8: If a write to a channel control word and a `done_i` or `err_i` pulse for that channel land in the same cycle, the written value is stored with bit 24 forced to 0.
- R9: `grant` is one-hot. It selects the lowest-indexed channel whose `may_xfer` bit is high, and it is 0 when no channel qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | High the cycle after a read strobe |
| req_i | input | 7 | Per-channel peripheral request |
| done_i | input | 7 | Per-channel completion pulse from the engine |
| err_i | input | 7 | Per-channel bus-error pulse from the engine |
| may_xfer | output | 7 | Per-channel transfer qualification |
| grant | output | 7 | One-hot lowest-index qualified channel |

## Verification
The properties take for granted that reset is held high from time zero through the first clock edges. They also assume that `done_i` and `err_i` are single-cycle pulses for channels that are actually in flight. The rule that a completion forces qualification low on the next cycle relies on the bus not setting the busy bit again in that same cycle; that case is the subject of R8. The stimulus changes inputs only on falling edges. It pulses completions and errors for exactly one cycle, and it never issues a read and a write together. This keeps every data check on a settled, unambiguous register state.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  // word offsets inside one 16-byte channel slot
  localparam logic [3:0] OFF_BASE = 4'h0;
  localparam logic [3:0] OFF_BLK  = 4'h4;
  localparam logic [3:0] OFF_CTL  = 4'h8;

  // global control word location
  localparam int PRIM_ADDR = 'h70;

  // reset ladder: nibble i carries priority i+1, enable clear
  function automatic logic [31:0] prim_reset(input int nch);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < nch && i < 8; i++) begin
      v[4*i +: 4] = 4'((i + 1) & 7);
    end
    return v;
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DATA_W   = 32,
  parameter int BUSY_BIT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel_base,
  input  logic              sel_blk,
  input  logic              sel_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic              err,
  input  logic              req,
  input  logic              master_en,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] blk_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic              may_xfer
);

  logic              req_q;
  logic [DATA_W-1:0] ctl_n;

  // completion or error dominates a same-cycle software set of busy
  always_comb begin
    ctl_n = ctl_q;
    if (wr_en && sel_ctl) ctl_n = wdata;
    if (done || err)      ctl_n[BUSY_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      blk_q  <= '0;
      ctl_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      if (wr_en && sel_base) base_q <= wdata;
      if (wr_en && sel_blk)  blk_q  <= wdata;
      ctl_q <= ctl_n;
      req_q <= req;
    end
  end

  assign may_xfer = master_en & ctl_q[BUSY_BIT] & req_q;

endmodule

// File: rtl/dma_prim_ctrl.sv
module dma_prim_ctrl import dma_regbank_pkg::*; #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] prim_q,
  output logic [NUM_CH-1:0] master_en
);

  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(prim_reset(NUM_CH));

  always_ff @(posedge clk) begin
    if (rst)     prim_q <= RST_VAL;
    else if (wr) prim_q <= wdata;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    assign master_en[g] = prim_q[4*g + 3];
  end

endmodule

// File: rtl/dma_grant_sel.sv
module dma_grant_sel #(
  parameter int NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] cand,
  output logic [NUM_CH-1:0] grant
);

  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank import dma_regbank_pkg::*; #(
  parameter int NUM_CH   = 7,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int BUSY_BIT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] err_i,
  output logic [NUM_CH-1:0] may_xfer,
  output logic [NUM_CH-1:0] grant
);

  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  idx;
  logic [3:0]        off;
  logic              prim_sel;
  logic [NUM_CH-1:0] sel_base, sel_blk, sel_ctl;
  logic [NUM_CH-1:0] master_en;
  logic [DATA_W-1:0] prim_q;
  logic [DATA_W-1:0] base_q [NUM_CH];
  logic [DATA_W-1:0] blk_q  [NUM_CH];
  logic [DATA_W-1:0] ctl_q  [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  assign idx      = addr[ADDR_W-1:4];
  assign off      = addr[3:0];
  assign prim_sel = (addr == ADDR_W'(PRIM_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic slot;
    assign slot        = (idx == IDX_W'(g));
    assign sel_base[g] = slot && (off == OFF_BASE);
    assign sel_blk[g]  = slot && (off == OFF_BLK);
    assign sel_ctl[g]  = slot && (off == OFF_CTL);

    dma_chan_regs #(.DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .sel_base  (sel_base[g]),
      .sel_blk   (sel_blk[g]),
      .sel_ctl   (sel_ctl[g]),
      .wdata     (wdata),
      .done      (done_i[g]),
      .err       (err_i[g]),
      .req       (req_i[g]),
      .master_en (master_en[g]),
      .base_q    (base_q[g]),
      .blk_q     (blk_q[g]),
      .ctl_q     (ctl_q[g]),
      .may_xfer  (may_xfer[g])
    );
  end

  dma_prim_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_prim (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_en && prim_sel),
    .wdata     (wdata),
    .prim_q    (prim_q),
    .master_en (master_en)
  );

  dma_grant_sel #(.NUM_CH(NUM_CH)) u_grant (
    .cand  (may_xfer),
    .grant (grant)
  );

  // unmapped offsets fall through to all ones
  always_comb begin
    rd_mux = '1;
    if (prim_sel) rd_mux = prim_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_base[i]) rd_mux = base_q[i];
      if (sel_blk[i])  rd_mux = blk_q[i];
      if (sel_ctl[i])  rd_mux = ctl_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] err_i,
  input logic [NUM_CH-1:0] may_xfer,
  input logic [NUM_CH-1:0] grant
);

  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  p_rvalid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  p_hole_reads_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[3:0] == 4'hC || addr == ADDR_W'('h74))) |=> (rdata == '1));

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_grant_subset_r9: assert property (@(posedge clk) disable iff (rst)
    (grant & ~may_xfer) == '0);

  p_grant_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    (may_xfer != '0) |-> (grant != '0) && (((grant - 1'b1) & may_xfer) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    p_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
      may_xfer[g] |-> $past(req_i[g]));

    p_done_drops_r6: assert property (@(posedge clk) disable iff (rst)
      done_i[g] |=> !may_xfer[g]);

    p_err_drops_r7: assert property (@(posedge clk) disable iff (rst)
      err_i[g] |=> !may_xfer[g]);
  end

endmodule

bind dma_regbank dma_regbank_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .rvalid(rvalid), .req_i(req_i), .done_i(done_i), .err_i(err_i),
  .may_xfer(may_xfer), .grant(grant)
);

// File: tb/dma_regbank_tb_top.sv
module dma_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [6:0]  req_i = '0, done_i = '0, err_i = '0;
  logic [6:0]  may_xfer, grant;

  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dma_regbank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .req_i(req_i),
    .done_i(done_i), .err_i(err_i), .may_xfer(may_xfer), .grant(grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rvalid ? rdata : 32'hDEAD_BEEF;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 may_xfer", {25'd0, may_xfer}, 32'd0);
    chk("R1 grant", {25'd0, grant}, 32'd0);
    rd(8'h70, d); chk("R1 global word", d, 32'h0765_4321);
    for (int c = 0; c < 7; c++) begin
      rd(8'(c*16 + 0), d); chk("R1 base", d, 32'd0);
      rd(8'(c*16 + 4), d); chk("R1 block", d, 32'd0);
      rd(8'(c*16 + 8), d); chk("R1 ctrl", d, 32'd0);
    end
  endtask

  task automatic t_decode();
    logic [31:0] d;
    for (int c = 0; c < 7; c++) begin
      wr(8'(c*16 + 0), 32'hA000_0000 | 32'(c << 8));
      wr(8'(c*16 + 4), 32'hB000_0010 | 32'(c << 12));
      wr(8'(c*16 + 8), 32'h1000_0700 | 32'(c));
    end
    for (int c = 0; c < 7; c++) begin
      rd(8'(c*16 + 0), d); chk("R2 base", d, 32'hA000_0000 | 32'(c << 8));
      rd(8'(c*16 + 4), d); chk("R2 block", d, 32'hB000_0010 | 32'(c << 12));
      rd(8'(c*16 + 8), d); chk("R2 ctrl", d, 32'h1000_0700 | 32'(c));
    end
    @(negedge clk);
    chk("R2 rvalid idle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_primary();
    logic [31:0] d;
    wr(8'h70, 32'h0FED_CBA9);
    rd(8'h70, d); chk("R3 global rw", d, 32'h0FED_CBA9);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h0C, 32'h1234_5678);
    wr(8'h74, 32'h0);
    wr(8'h01, 32'h5555_5555);
    wr(8'h79, 32'h0);
    wr(8'h90, 32'h0);
    rd(8'h0C, d); chk("R4 slot hole", d, 32'hFFFF_FFFF);
    rd(8'h74, d); chk("R4 irq slot", d, 32'hFFFF_FFFF);
    rd(8'h7C, d); chk("R4 top hole", d, 32'hFFFF_FFFF);
    rd(8'h90, d); chk("R4 above map", d, 32'hFFFF_FFFF);
    rd(8'h01, d); chk("R4 misaligned", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R4 base0 kept", d, 32'hA000_0000);
    rd(8'h70, d); chk("R4 global kept", d, 32'h0FED_CBA9);
  endtask

  task automatic t_qualify();
    wr(8'h28, 32'h0100_0000);
    settle();
    chk("R5 no req", {25'd0, may_xfer}, 32'd0);
    req_i = 7'b000_0100;
    settle();
    chk("R5 all three", {25'd0, may_xfer}, 32'h4);
    wr(8'h70, 32'h0FED_C3A9);
    chk("R5 master off", {25'd0, may_xfer}, 32'h0);
    wr(8'h70, 32'h0FED_CBA9);
    chk("R5 master on", {25'd0, may_xfer}, 32'h4);
    wr(8'h28, 32'h0000_0000);
    chk("R5 busy off", {25'd0, may_xfer}, 32'h0);
    req_i = '0;
    settle();
  endtask

  task automatic t_done();
    logic [31:0] d;
    wr(8'h38, 32'h1100_00AB);
    req_i = 7'b000_1000;
    settle();
    chk("R6 armed", {25'd0, may_xfer}, 32'h8);
    done_i = 7'b000_1000;
    @(negedge clk);
    done_i = '0;
    chk("R6 qual dropped", {25'd0, may_xfer}, 32'h0);
    rd(8'h38, d); chk("R6 busy cleared", d, 32'h1000_00AB);
    req_i = '0;
    settle();
  endtask

  task automatic t_err();
    logic [31:0] d;
    wr(8'h58, 32'h0300_0042);
    req_i = 7'b010_0000;
    settle();
    chk("R7 armed", {25'd0, may_xfer}, 32'h20);
    err_i = 7'b010_0000;
    @(negedge clk);
    err_i = '0;
    chk("R7 qual dropped", {25'd0, may_xfer}, 32'h0);
    rd(8'h58, d); chk("R7 busy cleared", d, 32'h0200_0042);
    req_i = '0;
    settle();
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h18; wdata = 32'h1100_0001; done_i = 7'b000_0010;
    @(negedge clk);
    wr_en = 1'b0; done_i = '0;
    rd(8'h18, d); chk("R8 done wins", d, 32'h1000_0001);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h68; wdata = 32'h0100_0000; err_i = 7'b100_0000;
    @(negedge clk);
    wr_en = 1'b0; err_i = '0;
    rd(8'h68, d); chk("R8 err wins", d, 32'h0000_0000);
  endtask

  task automatic t_grant();
    wr(8'h18, 32'h0100_0000);
    wr(8'h48, 32'h0100_0000);
    wr(8'h68, 32'h0100_0000);
    req_i = 7'b111_1111;
    settle();
    chk("R9 qualified set", {25'd0, may_xfer}, 32'h52);
    chk("R9 lowest ch1", {25'd0, grant}, 32'h02);
    done_i = 7'b000_0010;
    @(negedge clk);
    done_i = '0;
    chk("R9 next ch4", {25'd0, grant}, 32'h10);
    err_i = 7'b001_0000;
    @(negedge clk);
    err_i = '0;
    chk("R9 last ch6", {25'd0, grant}, 32'h40);
    req_i = '0;
    settle();
    chk("R9 none", {25'd0, grant}, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_primary();
    t_unmapped();
    t_qualify();
    t_done();
    t_err();
    t_race();
    t_grant();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule